// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block merges the four interrupt causes of a UART into one active-high request line and a byte the CPU can read to learn which cause to serve first. The four causes, from most to least urgent, are a receive error, a received character waiting, an empty transmit holding register, and a change on a modem control line. The error detectors, receiver, transmitter and modem input logic sit outside the block. They report through single-cycle event pulses and one level flag, and the register decoder reports CPU accesses as strobes.

Each cause has a pending bit that its own events set and its own register access clears. A four-bit enable register masks each cause on its way to the request line and the identification byte. Masking never stops a pending bit from being set, so turning a mask bit on later exposes an event that is already waiting. The identification byte shows the highest-priority enabled cause. It is frozen while the CPU's read strobe is asserted. A read that reports the transmit-empty cause counts as that cause's acknowledgement.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `iir_data` reads 8'h01, every pending bit is clear, and the enable register is 0.
- R2: Priority from highest to lowest is line error, receive data, transmit empty, modem. `iir_data[0]` is 0 when any enabled cause is pending and 1 when none is. `iir_data[2:1]` names the reported cause: 2'b11 line error, 2'b10 receive data, 2'b01 transmit empty, 2'b00 modem.
- R3: `iir_data` bits above bit 2 always read 0.
- R4: A pulse on any bit of `ls_err_evt` sets the line-error pending bit. A cycle with `lsr_rd` high clears it.
- R5: A pulse on `rx_avail_evt` sets the receive-data pending bit. A cycle with `rbr_rd` high clears it.
- R6: A 0-to-1 change of `thr_empty` sets the transmit-empty pending bit. A cycle with `thr_wr` high clears it.
- R7: The first cycle of an `iir_rd` strobe clears the transmit-empty pending bit when the byte being read reports transmit empty. A read that reports any other cause leaves that bit set.
- R8: An enable write that raises `ier_wd[2]` from 0 to 1 while `thr_empty` is 1 sets the transmit-empty pending bit.
- R9: A pulse on any bit of `ms_delta_evt` sets the modem pending bit. A cycle with `msr_rd` high clears it.
- R10: `ier_wd` bit 0 enables line error, bit 1 receive data, bit 2 transmit empty and bit 3 modem, and the value is stored on `ier_wr`. A disabled cause drives neither `irq` nor `iir_data`, but its pending bit still sets, and enabling it later reports it.
- R11: When no read strobe was active in the previous cycle, `irq` is high exactly when `iir_data[0]` is 0. `irq` always reflects the live pending state.
- R12: `iir_data` is captured when `iir_rd` rises and holds that value until `iir_rd` falls.
- R13: If a set event and that cause's clearing access fall in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wd | input | 4 | Enable register write data |
| ls_err_evt | input | LS_ERR_W (4) | Receive error event pulses (overrun, parity, framing, break) |
| rx_avail_evt | input | 1 | New received character event pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| ms_delta_evt | input | MS_DELTA_W (4) | Modem line change event pulses |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe, may last several cycles |
| irq | output | 1 | Active-high interrupt request |
| iir_data | output | DATA_W (8) | Identification byte |

## Verification
The bench builds the block with its defaults: an 8-bit identification byte, four error event lines and four modem change lines. With four enable bits, the random phase can reach all sixteen mask combinations. With four event lines per multi-input cause, it can hit every single-bit and multi-bit error or modem pattern. Read strobes of random length, and transmit-empty edges that land on an identification read, bring the capture-and-clear interplay within reach. Directed cases cover simultaneous set and clear and the rule that raising an enable bit sets the transmit-empty cause.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_LINE = 2'd0,
    SRC_RXD  = 2'd1,
    SRC_THRE = 2'd2,
    SRC_MDM  = 2'd3
  } src_e;

  localparam logic [2:0] ID_NONE = 3'b001;

  function automatic logic [2:0] id_code(src_e s);
    case (s)
      SRC_LINE: id_code = 3'b110;
      SRC_RXD:  id_code = 3'b100;
      SRC_THRE: id_code = 3'b010;
      default:  id_code = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_src_latch.sv
module uart_irq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  // A fresh event beats an acknowledgement in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output src_e               top_o,
  output logic [2:0]         id_o
);

  always_comb begin
    any_o = |req_i;
    top_o = SRC_LINE;
    // Walk from lowest to highest priority so the last hit wins.
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) top_o = src_e'(i[1:0]);
    end
    id_o = any_o ? id_code(top_o) : ID_NONE;
  end

endmodule

// File: rtl/uart_irq_id_hold.sv
module uart_irq_id_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] live_i,
  output logic              rd_start_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [DATA_W-1:0] IDLE_VAL = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              rd_q;
  logic [DATA_W-1:0] hold_q;

  assign rd_start_o = rd_i & ~rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      hold_q <= IDLE_VAL;
    end else begin
      rd_q <= rd_i;
      if (rd_start_o) hold_q <= live_i;
    end
  end

  // The first strobe cycle shows the live value, which is the value captured.
  assign data_o = rd_q ? hold_q : live_i;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LS_ERR_W   = 4,
  parameter int MS_DELTA_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ier_wr,
  input  logic [NUM_SRC-1:0]    ier_wd,
  input  logic [LS_ERR_W-1:0]   ls_err_evt,
  input  logic                  rx_avail_evt,
  input  logic                  thr_empty,
  input  logic [MS_DELTA_W-1:0] ms_delta_evt,
  input  logic                  lsr_rd,
  input  logic                  rbr_rd,
  input  logic                  msr_rd,
  input  logic                  thr_wr,
  input  logic                  iir_rd,
  output logic                  irq,
  output logic [DATA_W-1:0]     iir_data
);

  localparam int PAD_W = DATA_W - 3;

  logic [NUM_SRC-1:0] ier_q;
  logic               thr_empty_q;
  logic [NUM_SRC-1:0] src_set;
  logic [NUM_SRC-1:0] src_clr;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en_pend;
  logic               any_pend;
  src_e               top_src;
  logic [2:0]         id;
  logic [DATA_W-1:0]  live_iir;
  logic               rd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q       <= '0;
      thr_empty_q <= 1'b1;
    end else begin
      thr_empty_q <= thr_empty;
      if (ier_wr) ier_q <= ier_wd;
    end
  end

  always_comb begin
    src_set[SRC_LINE] = |ls_err_evt;
    src_set[SRC_RXD]  = rx_avail_evt;
    src_set[SRC_THRE] = (thr_empty & ~thr_empty_q)
                      | (ier_wr & ier_wd[SRC_THRE] & ~ier_q[SRC_THRE] & thr_empty);
    src_set[SRC_MDM]  = |ms_delta_evt;

    src_clr[SRC_LINE] = lsr_rd;
    src_clr[SRC_RXD]  = rbr_rd;
    src_clr[SRC_THRE] = thr_wr | (rd_start & any_pend & (top_src == SRC_THRE));
    src_clr[SRC_MDM]  = msr_rd;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    uart_irq_src_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (src_set[g]),
      .clr_i  (src_clr[g]),
      .pend_o (pend[g])
    );
  end

  assign en_pend = pend & ier_q;

  uart_irq_prio_enc u_enc (
    .req_i (en_pend),
    .any_o (any_pend),
    .top_o (top_src),
    .id_o  (id)
  );

  assign live_iir = {{PAD_W{1'b0}}, id};
  assign irq      = any_pend;

  uart_irq_id_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (iir_rd),
    .live_i     (live_iir),
    .rd_start_o (rd_start),
    .data_o     (iir_data)
  );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int DATA_W     = 8,
  parameter int LS_ERR_W   = 4,
  parameter int MS_DELTA_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ier_wr,
  input logic [LS_ERR_W-1:0]   ls_err_evt,
  input logic                  rx_avail_evt,
  input logic                  thr_empty,
  input logic [MS_DELTA_W-1:0] ms_delta_evt,
  input logic                  lsr_rd,
  input logic                  rbr_rd,
  input logic                  msr_rd,
  input logic                  thr_wr,
  input logic                  iir_rd,
  input logic                  irq,
  input logic [DATA_W-1:0]     iir_data
);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iir_data[DATA_W-1:3] == '0); // R3

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(iir_rd) |-> (irq == !iir_data[0])); // R11

  AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && $past(iir_rd)) |-> $stable(iir_data)); // R12

  AST_LSR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !(|ls_err_evt) && !iir_rd) |=> (iir_data[2:0] != 3'b110)); // R4

  AST_RBR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && !rx_avail_evt && !iir_rd) |=> (iir_data[2:0] != 3'b100)); // R5

  AST_THR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !ier_wr && !(thr_empty && !$past(thr_empty)) && !iir_rd)
      |=> (iir_data[2:0] != 3'b010)); // R6

  AST_MSR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !(|ms_delta_evt) && !iir_rd) |=> (iir_data[2:0] != 3'b000)); // R9

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
  .DATA_W     (DATA_W),
  .LS_ERR_W   (LS_ERR_W),
  .MS_DELTA_W (MS_DELTA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ier_wr       (ier_wr),
  .ls_err_evt   (ls_err_evt),
  .rx_avail_evt (rx_avail_evt),
  .thr_empty    (thr_empty),
  .ms_delta_evt (ms_delta_evt),
  .lsr_rd       (lsr_rd),
  .rbr_rd       (rbr_rd),
  .msr_rd       (msr_rd),
  .thr_wr       (thr_wr),
  .iir_rd       (iir_rd),
  .irq          (irq),
  .iir_data     (iir_data)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

  localparam int DATA_W = 8;
  localparam int LSW    = 4;
  localparam int MSW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ier_wr = 1'b0;
  logic [3:0]       ier_wd = '0;
  logic [LSW-1:0]   ls_err_evt = '0;
  logic             rx_avail_evt = 1'b0;
  logic             thr_empty = 1'b0;
  logic [MSW-1:0]   ms_delta_evt = '0;
  logic             lsr_rd = 1'b0;
  logic             rbr_rd = 1'b0;
  logic             msr_rd = 1'b0;
  logic             thr_wr = 1'b0;
  logic             iir_rd = 1'b0;
  logic             irq;
  logic [DATA_W-1:0] iir_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state, bit order: 0 line, 1 rx data, 2 thr empty, 3 modem
  logic [3:0] m_pend, m_ier;
  logic       m_thrq, m_rdq;
  logic [7:0] m_hold;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.DATA_W(DATA_W), .LS_ERR_W(LSW), .MS_DELTA_W(MSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wd(ier_wd),
    .ls_err_evt(ls_err_evt), .rx_avail_evt(rx_avail_evt), .thr_empty(thr_empty),
    .ms_delta_evt(ms_delta_evt), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .msr_rd(msr_rd),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .irq(irq), .iir_data(iir_data)
  );

  function automatic logic [7:0] live_id(logic [3:0] ep);
    if (ep[0])      return 8'h06;
    else if (ep[1]) return 8'h04;
    else if (ep[2]) return 8'h02;
    else if (ep[3]) return 8'h00;
    else            return 8'h01;
  endfunction

  function automatic logic [7:0] exp_iir();
    return m_rdq ? m_hold : live_id(m_pend & m_ier);
  endfunction

  task automatic model_reset();
    m_pend = '0; m_ier = '0; m_thrq = 1'b1; m_rdq = 1'b0; m_hold = 8'h01;
  endtask

  task automatic model_step();
    logic [7:0] lv;
    logic       start;
    logic [3:0] s, c;
    lv    = live_id(m_pend & m_ier);
    start = iir_rd & ~m_rdq;
    s[0] = |ls_err_evt;
    s[1] = rx_avail_evt;
    s[2] = (thr_empty & ~m_thrq) | (ier_wr & ier_wd[2] & ~m_ier[2] & thr_empty);
    s[3] = |ms_delta_evt;
    c[0] = lsr_rd;
    c[1] = rbr_rd;
    c[2] = thr_wr | (start & (lv == 8'h02));
    c[3] = msr_rd;
    for (int i = 0; i < 4; i++) begin
      if (s[i])      m_pend[i] = 1'b1;
      else if (c[i]) m_pend[i] = 1'b0;
    end
    if (start) m_hold = lv;
    m_rdq  = iir_rd;
    m_thrq = thr_empty;
    if (ier_wr) m_ier = ier_wd;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    ier_wr = 1'b0; ls_err_evt = '0; rx_avail_evt = 1'b0; ms_delta_evt = '0;
    lsr_rd = 1'b0; rbr_rd = 1'b0; msr_rd = 1'b0; thr_wr = 1'b0;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_both(string req, logic exp_irq, logic [7:0] exp_id);
    chk(req, {7'd0, irq}, {7'd0, exp_irq});
    chk(req, iir_data, exp_id);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_both("R1 reset", 1'b0, 8'h01);

    ier_wr = 1'b1; ier_wd = 4'hF; step();
    chk_both("R10 enabled idle", 1'b0, 8'h01);

    ls_err_evt = 4'b0100; step();
    chk_both("R4 line set", 1'b1, 8'h06);
    rx_avail_evt = 1'b1; step();
    chk_both("R2 line over rx", 1'b1, 8'h06);
    lsr_rd = 1'b1; step();
    chk_both("R4 line clear", 1'b1, 8'h04);
    rbr_rd = 1'b1; step();
    chk_both("R5 rx clear", 1'b0, 8'h01);

    thr_empty = 1'b1; step();
    chk_both("R6 thre set", 1'b1, 8'h02);
    ms_delta_evt = 4'b1001; step();
    chk_both("R2 thre over modem", 1'b1, 8'h02);

    iir_rd = 1'b1; step();
    chk("R12 captured", iir_data, 8'h02);
    step();
    chk("R12 held", iir_data, 8'h02);
    iir_rd = 1'b0; step();
    chk_both("R7 thre cleared by id read", 1'b1, 8'h00);
    msr_rd = 1'b1; step();
    chk_both("R9 modem clear", 1'b0, 8'h01);

    ier_wr = 1'b1; ier_wd = 4'h0; step();
    ier_wr = 1'b1; ier_wd = 4'b0100; step();
    chk_both("R8 enable rise sets thre", 1'b1, 8'h02);
    thr_wr = 1'b1; step();
    chk_both("R6 thre cleared by write", 1'b0, 8'h01);

    ier_wr = 1'b1; ier_wd = 4'hF; thr_empty = 1'b0; step();
    thr_empty = 1'b1; step();
    ls_err_evt = 4'b0001; step();
    chk_both("R2 line over thre", 1'b1, 8'h06);
    iir_rd = 1'b1; step();
    iir_rd = 1'b0; step();
    lsr_rd = 1'b1; step();
    chk_both("R7 other read keeps thre", 1'b1, 8'h02);
    thr_wr = 1'b1; step();

    ier_wr = 1'b1; ier_wd = 4'b1110; step();
    ls_err_evt = 4'b1000; step();
    chk_both("R10 masked line", 1'b0, 8'h01);
    ier_wr = 1'b1; ier_wd = 4'hF; step();
    chk_both("R10 unmask reveals line", 1'b1, 8'h06);
    lsr_rd = 1'b1; step();

    ls_err_evt = 4'b0010; lsr_rd = 1'b1; step();
    chk_both("R13 set wins", 1'b1, 8'h06);
    lsr_rd = 1'b1; step();
    chk_both("R13 later clear", 1'b0, 8'h01);

    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      ier_wr       = ($urandom % 16) == 0;
      ier_wd       = 4'($urandom);
      ls_err_evt   = (($urandom % 8) == 0) ? 4'($urandom) : 4'd0;
      rx_avail_evt = ($urandom % 8) == 0;
      ms_delta_evt = (($urandom % 8) == 0) ? 4'($urandom) : 4'd0;
      lsr_rd       = ($urandom % 6) == 0;
      rbr_rd       = ($urandom % 6) == 0;
      msr_rd       = ($urandom % 6) == 0;
      thr_wr       = ($urandom % 6) == 0;
      if (($urandom % 8) == 0) thr_empty = ~thr_empty;
      iir_rd       = iir_rd ? (($urandom % 4) != 0) : (($urandom % 5) == 0);
      step();
      chk("R2 R11 random irq", {7'd0, irq}, {7'd0, |(m_pend & m_ier)});
      chk("R2 R3 R12 random id", iir_data, exp_iir());
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule